// File: doc/BRIEF.md
# Serial Port Register and Interrupt Unit

This block is the software-visible face of a serial port. A processor reaches it through a simple peripheral bus slave: one setup cycle, then an access cycle with `penable` high. Behind the bus sit a transmit byte queue, a receive byte queue, sticky line-error flags, the control word that configures the serial engine, a 12-bit baud scaler, and a single interrupt line. The block contains no bit-level serial timing and no baud divider. The serial engine attaches through a transmit byte stream, a receive byte input and three one-cycle error pulses. The control fields that the engine needs reach it as plain output pins.

The word offsets are fixed because software decodes them:

| Offset | Register |
|---|---|
| 0x00 | data |
| 0x04 | status |
| 0x08 | control |
| 0x0C | scaler |
| 0x10 | FIFO debug |

Transmit stream rules:
- A byte moves on every rising edge where `tx_valid` and `tx_ready` are both high.
- While `tx_valid` is high and `tx_ready` is low, `tx_data` holds its value.

Receive stream rules:
- The receive side applies no back-pressure, so there is no ready pin.
- A byte is taken on any edge with `rx_valid` high.
- If the receive queue is full at that edge, the byte is discarded and the overrun flag is set.

With the default parameters each queue holds 8 bytes. Setting `USE_FIFO` to 0 reduces each queue to a single holding register.

Top module: `sio_reg_unit`

## Requirements
- R1: After reset the registers read as follows.
  - Status reads 0x86: bit 1 shift-idle, bit 2 transmit empty and bit 7 transmit at-or-below-half are set, with `tx_idle` high.
  - Control reads 0x8000_0000. Bit 31 is a read-only 1 because queues are built in; bits 14:0 are zero.
  - Scaler reads 0 and keeps only its low 12 bits.
  - Offsets 0x10 (outside debug mode) and unmapped offsets read 0.
- R2: A write to data pushes bits 7:0 into the transmit queue; a write while the queue is full is dropped. Bytes leave on the transmit stream in write order. `tx_valid` is high only when control bit 1 is set and debug mode is off.
- R3: Transmit status fields:
  - bit 2 is high when the queue is empty;
  - bit 1 is high when the queue is empty and `tx_idle` is high;
  - bit 7 is high when the count is 4 or less;
  - bit 9 is high when the queue is full;
  - bits 25:20 hold the count.
- R4: A receive byte is accepted only when control bit 0 is set, and a data read pops the oldest byte. Receive status fields:
  - bit 0 is high when the queue is not empty;
  - bit 8 is high when the count is 4 or more;
  - bit 10 is high when the queue is full;
  - bits 31:26 hold the count.
  A data read on an empty queue returns 0 and changes nothing.
- R5: With control bit 0 clear and debug mode off, bytes on the receive input are ignored: the count and status bit 0 stay 0.
- R6: A byte that arrives while the receive queue is full is discarded, status bit 4 (overrun) is set, and the queued bytes are unchanged.
- R7: The error flags are sticky: a frame pulse sets status bit 6, a parity pulse sets bit 5 and a break pulse sets bit 3. A status write clears each flag whose written bit is 0 and keeps each flag whose written bit is 1. A pulse in the same cycle wins over the clear.
- R8: `irq` is high while control bit 2 is set and status bit 0 is set. It is also high while control bit 10 is set and status bit 8 is set.
- R9: `irq` is high while control bit 9 is set and status bit 7 is set.
- R10: With control bit 3 set, `irq` pulses for exactly one cycle in the cycle after the transmit queue goes from non-empty to empty.
- R11: One-cycle `irq` pulses from edge events:
  - with control bit 14 set, a pulse when status bit 1 rises;
  - with control bit 12 set, a pulse in the cycle after a break pulse.
- R12: Debug mode is control bit 11. In debug mode:
  - `tx_valid` stays low;
  - a write to 0x10 pushes a byte into the receive queue;
  - a read of 0x10 pops the transmit queue;
  - engine bytes are ignored.
- R13: The configuration pins follow the control register: bit 0 receive enable, bit 1 transmit enable, bit 4 odd parity, bit 5 parity enable, bit 6 flow control, bit 7 loopback, bit 8 external clock. `cfg_scaler` follows the scaler register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | Write when high |
| paddr | input | ADDR_W | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Engine takes the byte |
| tx_data | output | 8 | Transmit byte |
| tx_idle | input | 1 | Engine shift register empty |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_frame_err | input | 1 | Framing error pulse |
| rx_parity_err | input | 1 | Parity error pulse |
| rx_break | input | 1 | Break detected pulse |
| cfg_rx_en | output | 1 | Receiver enable |
| cfg_tx_en | output | 1 | Transmitter enable |
| cfg_par_en | output | 1 | Parity enable |
| cfg_par_odd | output | 1 | Odd parity select |
| cfg_flow_en | output | 1 | Flow control enable |
| cfg_loopback | output | 1 | Loopback |
| cfg_ext_clk | output | 1 | External baud clock |
| cfg_scaler | output | SCALER_W | Baud scaler value |
| irq | output | 1 | Interrupt request |

## Verification
The queues are swept one byte at a time from empty past full: 10 transmit writes and 9 receive bytes. At each step the complete status word is compared with a value the bench computes from the count. These sweeps separate the half threshold from the full threshold and show that surplus bytes are dropped. Draining checks byte order and places the transmit-empty pulse in its exact cycle.

All 32 combinations of the five line-configuration bits are written and checked on the pins. Each interrupt source is enabled alone and toggled across its threshold, which separates level behaviour from one-cycle pulses. Error pulses are followed by masked status writes to show selective clearing.

// File: rtl/sio_pkg.sv
package sio_pkg;

  localparam logic [4:0] OFS_DATA = 5'h00;
  localparam logic [4:0] OFS_STAT = 5'h04;
  localparam logic [4:0] OFS_CTRL = 5'h08;
  localparam logic [4:0] OFS_SCAL = 5'h0C;
  localparam logic [4:0] OFS_DBG  = 5'h10;

  localparam int CTRL_W = 15;

  // Bit positions are software-visible; field i of the word is bit i.
  typedef struct packed {
    logic irq_txidle_en;   // 14
    logic irq_delay_en;    // 13 (stored only)
    logic irq_break_en;    // 12
    logic dbg_mode;        // 11
    logic irq_rxlvl_en;    // 10
    logic irq_txlvl_en;    // 9
    logic ext_clk;         // 8
    logic loopback;        // 7
    logic flow_en;         // 6
    logic par_en;          // 5
    logic par_odd;         // 4
    logic irq_txempty_en;  // 3
    logic irq_rx_en;       // 2
    logic tx_en;           // 1
    logic rx_en;           // 0
  } sio_ctrl_t;

  typedef struct packed {
    logic brk;
    logic ovr;
    logic par;
    logic frm;
  } sio_err_t;

endpackage

// File: rtl/sio_byte_fifo.sv
module sio_byte_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          wr_ok, rd_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
  assign count = cnt_q;
  assign wr_ok = push && !full;
  assign rd_ok = pop && !empty;
  assign dout  = mem[rp_q];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_ok) wp_q <= bump(wp_q);
      if (rd_ok) rp_q <= bump(rp_q);
      case ({wr_ok, rd_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_fifo_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full && !pop) |=> (count == $past(count) + 1'b1));

  assert_fifo_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> empty);

endmodule

// File: rtl/sio_err_flags.sv
module sio_err_flags
  import sio_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  sio_err_t set,
  input  logic     clr_wr,
  input  sio_err_t keep,
  output sio_err_t flags
);

  sio_err_t flags_q;

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (clr_wr ? (flags_q & keep) : flags_q) | set;
  end

  assign flags = flags_q;

  assert_err_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_wr && set == '0) |=> (flags == $past(flags)));

  assert_err_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && keep == '0 && set == '0) |=> (flags == '0));

endmodule

// File: rtl/sio_irq_gen.sv
module sio_irq_gen
  import sio_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  sio_ctrl_t ctrl,
  input  logic      rx_avail,
  input  logic      rx_half,
  input  logic      tx_half,
  input  logic      tx_empty,
  input  logic      tx_done,
  input  logic      brk,
  output logic      irq
);

  logic tx_empty_d, tx_done_d, brk_d;
  logic lvl, ti_p, si_p, bi_p;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_empty_d <= 1'b1;
      tx_done_d  <= 1'b1;
      brk_d      <= 1'b0;
    end else begin
      tx_empty_d <= tx_empty;
      tx_done_d  <= tx_done;
      brk_d      <= brk;
    end
  end

  assign lvl  = (ctrl.irq_rx_en    && rx_avail)
             || (ctrl.irq_rxlvl_en && rx_half)
             || (ctrl.irq_txlvl_en && tx_half);
  assign ti_p = ctrl.irq_txempty_en && tx_empty && !tx_empty_d;
  assign si_p = ctrl.irq_txidle_en  && tx_done  && !tx_done_d;
  assign bi_p = ctrl.irq_break_en   && brk_d;
  assign irq  = lvl || ti_p || si_p || bi_p;

  assert_rx_lvl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.irq_rx_en && rx_avail) |-> irq);

  assert_tx_lvl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.irq_txlvl_en && tx_half) |-> irq);

  assert_ti_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_empty) ##1 (tx_empty && ctrl.irq_txempty_en) |-> irq);

  assert_brk_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    brk ##1 ctrl.irq_break_en |-> irq);

endmodule

// File: rtl/sio_reg_unit.sv
module sio_reg_unit
  import sio_pkg::*;
#(
  parameter bit USE_FIFO = 1'b1,
  parameter int DEPTH    = 8,
  parameter int ADDR_W   = 5,
  parameter int SCALER_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                psel,
  input  logic                penable,
  input  logic                pwrite,
  input  logic [ADDR_W-1:0]   paddr,
  input  logic [31:0]         pwdata,
  output logic [31:0]         prdata,
  output logic                tx_valid,
  input  logic                tx_ready,
  output logic [7:0]          tx_data,
  input  logic                tx_idle,
  input  logic                rx_valid,
  input  logic [7:0]          rx_data,
  input  logic                rx_frame_err,
  input  logic                rx_parity_err,
  input  logic                rx_break,
  output logic                cfg_rx_en,
  output logic                cfg_tx_en,
  output logic                cfg_par_en,
  output logic                cfg_par_odd,
  output logic                cfg_flow_en,
  output logic                cfg_loopback,
  output logic                cfg_ext_clk,
  output logic [SCALER_W-1:0] cfg_scaler,
  output logic                irq
);

  localparam int FD   = USE_FIFO ? DEPTH : 1;
  localparam int CW   = $clog2(FD + 1);
  localparam int TH_T = FD / 2;
  localparam int RH_T = (FD + 1) / 2;

  sio_ctrl_t             ctrl_q;
  logic [SCALER_W-1:0]   scal_q;
  logic                  wr_acc, rd_acc;
  logic                  sel_data, sel_stat, sel_ctrl, sel_scal, sel_dbg;
  logic                  tx_push, tx_pop, tx_empty, tx_full;
  logic                  rx_push, rx_pop, rx_empty, rx_full;
  logic [7:0]            tx_head, rx_head, rx_din;
  logic [CW-1:0]         tx_cnt, rx_cnt;
  logic                  tx_half, rx_half, tx_done;
  sio_err_t              err_q, err_set, err_keep;
  logic [31:0]           stat_w;
  logic                  unused_wbits;

  function automatic logic [5:0] sat6(input logic [CW-1:0] v);
    logic [31:0] w;
    w = 32'(v);
    return (w > 32'd63) ? 6'd63 : w[5:0];
  endfunction

  // Bus decode
  assign wr_acc   = psel && penable && pwrite;
  assign rd_acc   = psel && penable && !pwrite;
  assign sel_data = (paddr == ADDR_W'(OFS_DATA));
  assign sel_stat = (paddr == ADDR_W'(OFS_STAT));
  assign sel_ctrl = (paddr == ADDR_W'(OFS_CTRL));
  assign sel_scal = (paddr == ADDR_W'(OFS_SCAL));
  assign sel_dbg  = (paddr == ADDR_W'(OFS_DBG));
  assign unused_wbits = ^pwdata[31:CTRL_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      scal_q <= '0;
    end else begin
      if (wr_acc && sel_ctrl) ctrl_q <= sio_ctrl_t'(pwdata[CTRL_W-1:0]);
      if (wr_acc && sel_scal) scal_q <= pwdata[SCALER_W-1:0];
    end
  end

  // Transmit path
  assign tx_push  = wr_acc && sel_data;
  assign tx_valid = !tx_empty && ctrl_q.tx_en && !ctrl_q.dbg_mode;
  assign tx_data  = tx_head;
  assign tx_pop   = (tx_valid && tx_ready)
                 || (rd_acc && sel_dbg && ctrl_q.dbg_mode);

  sio_byte_fifo #(.DEPTH(FD), .W(8)) u_txq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (tx_push),
    .din   (pwdata[7:0]),
    .pop   (tx_pop),
    .dout  (tx_head),
    .empty (tx_empty),
    .full  (tx_full),
    .count (tx_cnt)
  );

  // Receive path: debug mode swaps the engine for bus writes to the debug offset
  assign rx_push = ctrl_q.dbg_mode ? (wr_acc && sel_dbg) : (rx_valid && ctrl_q.rx_en);
  assign rx_din  = ctrl_q.dbg_mode ? pwdata[7:0] : rx_data;
  assign rx_pop  = rd_acc && sel_data;

  sio_byte_fifo #(.DEPTH(FD), .W(8)) u_rxq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (rx_push),
    .din   (rx_din),
    .pop   (rx_pop),
    .dout  (rx_head),
    .empty (rx_empty),
    .full  (rx_full),
    .count (rx_cnt)
  );

  // Error flags
  assign err_set  = '{brk: rx_break, ovr: rx_push && rx_full,
                      par: rx_parity_err, frm: rx_frame_err};
  assign err_keep = '{brk: pwdata[3], ovr: pwdata[4], par: pwdata[5], frm: pwdata[6]};

  sio_err_flags u_err (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (err_set),
    .clr_wr (wr_acc && sel_stat),
    .keep   (err_keep),
    .flags  (err_q)
  );

  // Status composition
  assign tx_half = (tx_cnt <= CW'(TH_T));
  assign rx_half = (rx_cnt >= CW'(RH_T));
  assign tx_done = tx_empty && tx_idle;

  always_comb begin
    stat_w        = '0;
    stat_w[0]     = !rx_empty;
    stat_w[1]     = tx_done;
    stat_w[2]     = tx_empty;
    stat_w[3]     = err_q.brk;
    stat_w[4]     = err_q.ovr;
    stat_w[5]     = err_q.par;
    stat_w[6]     = err_q.frm;
    stat_w[7]     = tx_half;
    stat_w[8]     = rx_half;
    stat_w[9]     = tx_full;
    stat_w[10]    = rx_full;
    stat_w[25:20] = sat6(tx_cnt);
    stat_w[31:26] = sat6(rx_cnt);
  end

  always_comb begin
    prdata = '0;
    if (sel_data)      prdata = rx_empty ? 32'd0 : {24'd0, rx_head};
    else if (sel_stat) prdata = stat_w;
    else if (sel_ctrl) prdata = {USE_FIFO, {(31 - CTRL_W){1'b0}}, ctrl_q};
    else if (sel_scal) prdata = 32'(scal_q);
    else if (sel_dbg)  prdata = (ctrl_q.dbg_mode && !tx_empty) ? {24'd0, tx_head} : 32'd0;
  end

  // Interrupts
  sio_irq_gen u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl     (ctrl_q),
    .rx_avail (!rx_empty),
    .rx_half  (rx_half),
    .tx_half  (tx_half),
    .tx_empty (tx_empty),
    .tx_done  (tx_done),
    .brk      (rx_break),
    .irq      (irq)
  );

  // Configuration pins
  assign cfg_rx_en    = ctrl_q.rx_en;
  assign cfg_tx_en    = ctrl_q.tx_en;
  assign cfg_par_en   = ctrl_q.par_en;
  assign cfg_par_odd  = ctrl_q.par_odd;
  assign cfg_flow_en  = ctrl_q.flow_en;
  assign cfg_loopback = ctrl_q.loopback;
  assign cfg_ext_clk  = ctrl_q.ext_clk;
  assign cfg_scaler   = scal_q;

  assert_tx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !(wr_acc && sel_ctrl)) |=> (tx_valid && $stable(tx_data)));

  assert_re_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.rx_en && !ctrl_q.dbg_mode && !rx_pop) |=> (rx_cnt == $past(rx_cnt)));

  assert_ovr_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_full) |=> (err_q.ovr && (rx_cnt == $past(rx_cnt) - CW'(rx_pop))));

  assert_cfg_follow_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && sel_ctrl) |=> (cfg_par_en == $past(pwdata[5])));

endmodule

// File: tb/tb_sio_reg_unit.sv
module tb_sio_reg_unit;
  localparam int CLK_PERIOD = 10;
  localparam int QD = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [4:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        tx_valid, tx_ready = 0, tx_idle = 1;
  logic [7:0]  tx_data;
  logic        rx_valid = 0, rx_frame_err = 0, rx_parity_err = 0, rx_break = 0;
  logic [7:0]  rx_data = '0;
  logic        cfg_rx_en, cfg_tx_en, cfg_par_en, cfg_par_odd, cfg_flow_en;
  logic        cfg_loopback, cfg_ext_clk, irq;
  logic [11:0] cfg_scaler;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sio_reg_unit dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_idle(tx_idle),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_frame_err(rx_frame_err),
    .rx_parity_err(rx_parity_err), .rx_break(rx_break),
    .cfg_rx_en(cfg_rx_en), .cfg_tx_en(cfg_tx_en), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_flow_en(cfg_flow_en), .cfg_loopback(cfg_loopback),
    .cfg_ext_clk(cfg_ext_clk), .cfg_scaler(cfg_scaler), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // e = {brk, ovr, par, frm}
  function automatic logic [31:0] exp_stat(input int rc, input int tc, input bit idle,
                                           input logic [3:0] e);
    logic [31:0] r;
    r = '0;
    r[0] = (rc != 0);
    r[1] = (tc == 0) && idle;
    r[2] = (tc == 0);
    r[3] = e[3];
    r[4] = e[2];
    r[5] = e[1];
    r[6] = e[0];
    r[7] = (tc <= QD / 2);
    r[8] = (rc >= QD / 2);
    r[9] = (tc == QD);
    r[10] = (rc == QD);
    r[25:20] = 6'(tc);
    r[31:26] = 6'(rc);
    return r;
  endfunction

  task automatic apb_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk);
    penable = 1;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk);
    penable = 1;
    #1 d = prdata;
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  task automatic rx_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1; rx_data = b;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic err_pulse(input logic f, input logic p, input logic b);
    @(negedge clk);
    rx_frame_err = f; rx_parity_err = p; rx_break = b;
    @(negedge clk);
    rx_frame_err = 0; rx_parity_err = 0; rx_break = 0;
  endtask

  task automatic tx_take(input logic [7:0] exp);
    @(negedge clk);
    chk("R2 tx_valid", 32'(tx_valid), 32'd1);
    chk("R2 tx_data order", 32'(tx_data), 32'(exp));
    tx_ready = 1;
    @(negedge clk);
    tx_ready = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R1 reset state and map
    apb_rd(5'h04, d); chk("R1 status reset", d, 32'h0000_0086);
    apb_rd(5'h08, d); chk("R1 ctrl reset", d, 32'h8000_0000);
    apb_rd(5'h0C, d); chk("R1 scaler reset", d, 32'h0);
    apb_rd(5'h00, d); chk("R1 data empty", d, 32'h0);
    apb_rd(5'h10, d); chk("R1 debug off", d, 32'h0);
    apb_rd(5'h14, d); chk("R1 unmapped", d, 32'h0);
    chk("R1 irq reset", 32'(irq), 32'd0);
    apb_wr(5'h0C, 32'hFFFF_FABC);
    apb_rd(5'h0C, d); chk("R1 scaler width", d, 32'h0000_0ABC);
    chk("R13 scaler pin", 32'(cfg_scaler), 32'h0ABC);

    // R13 line configuration sweep
    for (int v = 0; v < 32; v++) begin
      apb_wr(5'h08, 32'(v) << 4);
      chk("R13 cfg pins", 32'({cfg_ext_clk, cfg_loopback, cfg_flow_en, cfg_par_en, cfg_par_odd}),
          32'(v));
      apb_rd(5'h08, d); chk("R1 ctrl readback", d, 32'h8000_0000 | (32'(v) << 4));
    end
    apb_wr(5'h08, 32'h3);
    chk("R13 enables", 32'({cfg_tx_en, cfg_rx_en}), 32'd3);
    apb_wr(5'h08, 32'h0);

    // R2/R3 transmit fill sweep
    for (int n = 1; n <= 10; n++) begin
      apb_wr(5'h00, 32'h30 + 32'(n));
      apb_rd(5'h04, d);
      chk("R3 tx status", d, exp_stat(0, (n > QD) ? QD : n, 1'b1, 4'b0));
      chk("R2 tx held off", 32'(tx_valid), 32'd0);
    end
    apb_wr(5'h08, 32'h0000_000A);
    for (int k = 0; k < QD; k++) tx_take(8'h31 + 8'(k));
    chk("R10 ti pulse", 32'(irq), 32'd1);
    @(negedge clk);
    chk("R10 ti one cycle", 32'(irq), 32'd0);
    apb_rd(5'h04, d); chk("R3 tx drained", d, exp_stat(0, 0, 1'b1, 4'b0));

    // R9 transmit level interrupt
    apb_wr(5'h08, 32'h0000_0200);
    chk("R9 empty", 32'(irq), 32'd1);
    for (int n = 1; n <= 5; n++) begin
      apb_wr(5'h00, 32'h50 + 32'(n));
      chk("R9 level", 32'(irq), (n <= QD / 2) ? 32'd1 : 32'd0);
    end
    apb_wr(5'h08, 32'h0000_0002);
    for (int k = 1; k <= 5; k++) tx_take(8'h50 + 8'(k));

    // R11 shift-idle edge
    tx_idle = 0;
    apb_wr(5'h08, 32'h0000_4002);
    apb_wr(5'h00, 32'h11);
    tx_take(8'h11);
    chk("R11 idle low", 32'(irq), 32'd0);
    @(negedge clk);
    tx_idle = 1;
    #1 chk("R11 si pulse", 32'(irq), 32'd1);
    @(negedge clk);
    chk("R11 si one cycle", 32'(irq), 32'd0);

    // R11 break edge and R7 sticky flags
    apb_wr(5'h08, 32'h0000_1000);
    err_pulse(1'b0, 1'b0, 1'b1);
    chk("R11 bi pulse", 32'(irq), 32'd1);
    @(negedge clk);
    chk("R11 bi one cycle", 32'(irq), 32'd0);
    apb_wr(5'h08, 32'h0);
    err_pulse(1'b1, 1'b1, 1'b0);
    apb_rd(5'h04, d); chk("R7 flags set", d, exp_stat(0, 0, 1'b1, 4'b1011));
    apb_wr(5'h04, 32'h0000_0008);
    apb_rd(5'h04, d); chk("R7 masked clear", d, exp_stat(0, 0, 1'b1, 4'b1000));
    apb_wr(5'h04, 32'h0);
    apb_rd(5'h04, d); chk("R7 full clear", d, exp_stat(0, 0, 1'b1, 4'b0000));

    // R4/R6 receive fill sweep
    apb_wr(5'h08, 32'h1);
    for (int n = 1; n <= 9; n++) begin
      rx_byte(8'hA0 + 8'(n));
      apb_rd(5'h04, d);
      chk("R4 rx status / R6 ovr", d,
          exp_stat((n > QD) ? QD : n, 0, 1'b1, (n > QD) ? 4'b0100 : 4'b0));
    end
    for (int k = 1; k <= QD; k++) begin
      apb_rd(5'h00, d); chk("R6 rx order", d, 32'hA0 + 32'(k));
    end
    apb_rd(5'h00, d); chk("R4 empty read", d, 32'h0);
    apb_rd(5'h04, d); chk("R4 after empty read", d, exp_stat(0, 0, 1'b1, 4'b0100));
    apb_wr(5'h04, 32'h0);

    // R5 receiver disabled
    apb_wr(5'h08, 32'h0);
    rx_byte(8'h55);
    apb_rd(5'h04, d); chk("R5 ignored", d, exp_stat(0, 0, 1'b1, 4'b0));

    // R8 receive interrupts
    apb_wr(5'h08, 32'h5);
    chk("R8 idle", 32'(irq), 32'd0);
    rx_byte(8'h66);
    chk("R8 data ready", 32'(irq), 32'd1);
    apb_rd(5'h00, d); chk("R8 data", d, 32'h66);
    chk("R8 cleared", 32'(irq), 32'd0);
    apb_wr(5'h08, 32'h401);
    for (int n = 1; n <= 4; n++) begin
      rx_byte(8'h70 + 8'(n));
      chk("R8 half level", 32'(irq), (n >= QD / 2) ? 32'd1 : 32'd0);
    end
    for (int k = 1; k <= 4; k++) apb_rd(5'h00, d);
    chk("R8 drained", 32'(irq), 32'd0);

    // R12 debug mode
    apb_wr(5'h08, 32'h802);
    apb_wr(5'h00, 32'h5A);
    chk("R12 tx held", 32'(tx_valid), 32'd0);
    apb_wr(5'h08, 32'h803);
    rx_byte(8'h99);
    apb_rd(5'h10, d); chk("R12 debug pop tx", d, 32'h5A);
    apb_wr(5'h10, 32'h77);
    apb_rd(5'h04, d); chk("R12 status", d, exp_stat(1, 0, 1'b1, 4'b0));
    apb_rd(5'h00, d); chk("R12 debug push rx", d, 32'h77);
    apb_wr(5'h08, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule